// File: doc/BRIEF.md
# Second-level cache controller register stub

This block is a register-only placeholder for a second-level cache controller. Boot software can find it, read its identity and geometry, program its control and latency settings, and start maintenance operations that finish at once. No data is cached. Latency settings and address filter limits are stored and read back, but nothing acts on them.

Accesses arrive on a single-cycle slave port. A strobe marks the cycle, with write enable, address and write data in that same cycle. The response appears in the following cycle: ready is asserted, read data is valid, and a bad-access flag is raised if the offset is not decoded. Only the low 12 bits of the address are used, so the 4 KB register window repeats across the address space.

Top module: `cache_ctrl_stub`

## Requirements
- R1: After reset, these registers read as follows:
  - control reads 0;
  - auxiliary control (0x104) reads 0x02020000;
  - tag latency (0x108), data latency (0x10C), filter low (0xC00) and filter high (0xC04) read 0;
  - the geometry word starts from parameter `TYPE_RESET`, default 0x1C100100.
- R2: A read of offset 0x000 returns 0x410000C8. A write to 0x000 has no effect and raises the bad-access flag.
- R3: A write to the control register (0x100) keeps only bit 0. Bits 31:1 always read back as 0.
- R4: The registers at 0x104, 0x108, 0x10C, 0xC00 and 0xC04 store all 32 bits of a write and return them on a read.
- R5: A read of offset 0x004 builds a 5-bit fold value:
  - fold bits 4:2 are auxiliary bits 19:17;
  - fold bit 1 is 0;
  - fold bit 0 is auxiliary bit 16.
  The fold is ORed into the stored geometry word at bit 6 and at bit 18. The result is stored back and returned, so set bits accumulate across reads. A write to 0x004 has no effect and raises the bad-access flag.
- R6: Any offset from 0x730 up to 0x7FF reads as 0, meaning the operation is complete. Writes there change nothing, and neither reads nor writes raise the bad-access flag.
- R7: Offsets 0xF40, 0xF60 and 0xF80 read as 0 and ignore writes, without raising the bad-access flag.
- R8: Any other offset reads as 0, and a write to it changes no register. Either access raises the bad-access flag in its response cycle only.
- R9: Address bits above bit 11 are ignored. For example, 0x5104 reaches the auxiliary control register.
- R10: Every access has a response in the next cycle, with ready high. In a cycle with no access, ready, bad-access and read data are all 0. Read data is 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits 11:0 are decoded |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the response cycle |
| ready_o | output | 1 | Response cycle marker |
| bad_access_o | output | 1 | Undecoded offset or write to a read-only word |

## Verification
Every result is due exactly one clock edge after the access cycle. This covers read data, ready, the bad-access flag and the register update caused by a write. A write followed immediately by a read of the same offset therefore returns the new value. The bench drives each access at a falling edge and computes the expected response from a behavioural model. It compares all three outputs at the next falling edge, including in idle cycles. A change that write side effects, such as geometry accumulation or a discarded write, fail to cause is caught by a later read through the port.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;
  localparam logic [DATA_W-1:0] ID_WORD = 32'h4100_00C8;

  localparam logic [OFF_W-1:0] OFF_ID     = 12'h000;
  localparam logic [OFF_W-1:0] OFF_TYPE   = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAGLAT = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DATLAT = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FLO    = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FHI    = 12'hC04;
  localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFF_W-1:0] MAINT_HI   = 12'h800;

  typedef enum logic [3:0] {
    K_ID, K_TYPE, K_CTRL, K_AUX, K_TAGLAT, K_DATLAT,
    K_FLO, K_FHI, K_MAINT, K_SILENT, K_BAD
  } kind_e;

  // plain read/write registers, index 0 must stay auxiliary control
  localparam int NUM_RW = 5;
  localparam int RW_AUX = 0;

  function automatic kind_e rw_kind(input int i);
    case (i)
      0:       return K_AUX;
      1:       return K_TAGLAT;
      2:       return K_DATLAT;
      3:       return K_FLO;
      default: return K_FHI;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rw_reset(input int i);
    return (i == RW_AUX) ? 32'h0202_0000 : '0;
  endfunction
endpackage

// File: rtl/ccs_decode.sv
module ccs_decode
  import ccs_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  output kind_e            kind_o
);
  always_comb begin
    if (off_i >= MAINT_LO && off_i < MAINT_HI) begin
      kind_o = K_MAINT;
    end else begin
      case (off_i)
        OFF_ID:                      kind_o = K_ID;
        OFF_TYPE:                    kind_o = K_TYPE;
        OFF_CTRL:                    kind_o = K_CTRL;
        OFF_AUX:                     kind_o = K_AUX;
        OFF_TAGLAT:                  kind_o = K_TAGLAT;
        OFF_DATLAT:                  kind_o = K_DATLAT;
        OFF_FLO:                     kind_o = K_FLO;
        OFF_FHI:                     kind_o = K_FHI;
        12'hF40, 12'hF60, 12'hF80:   kind_o = K_SILENT;
        default:                     kind_o = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/ccs_rw_reg.sv
module ccs_rw_reg #(
  parameter int          W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ccs_type_word.sv
module ccs_type_word
  import ccs_pkg::*;
#(
  parameter logic [DATA_W-1:0] TYPE_RESET = 32'h1C10_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] aux_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] word_q;
  logic [4:0]        fold;

  assign fold  = {aux_i[19:17], 1'b0, aux_i[16]};
  assign val_o = word_q | (DATA_W'(fold) << 18) | (DATA_W'(fold) << 6);

  // every read makes the folded bits sticky
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= TYPE_RESET;
    else if (rd_i) word_q <= val_o;
  end
endmodule

// File: rtl/cache_ctrl_stub.sv
module cache_ctrl_stub
  import ccs_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [DATA_W-1:0] TYPE_RESET = 32'h1C10_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              bad_access_o
);
  kind_e             kind;
  logic              wr_en, rd_en, is_bad, ctrl_q;
  logic [DATA_W-1:0] rw_q [NUM_RW];
  logic [DATA_W-1:0] type_val, rd_val;

  assign wr_en  = sel_i & we_i;
  assign rd_en  = sel_i & ~we_i;
  assign is_bad = (kind == K_BAD) | (we_i & ((kind == K_ID) | (kind == K_TYPE)));

  ccs_decode u_dec (
    .off_i  (addr_i[OFF_W-1:0]),
    .kind_o (kind)
  );

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    ccs_rw_reg #(.W(DATA_W), .RST(rw_reset(g))) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (wr_en && kind == rw_kind(g)),
      .d_i    (wdata_i),
      .q_o    (rw_q[g])
    );
  end

  ccs_type_word #(.TYPE_RESET(TYPE_RESET)) u_type (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_en && kind == K_TYPE),
    .aux_i  (rw_q[RW_AUX]),
    .val_o  (type_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_q <= 1'b0;
    else if (wr_en && kind == K_CTRL)   ctrl_q <= wdata_i[0];
  end

  always_comb begin
    rd_val = '0;
    case (kind)
      K_ID:    rd_val = ID_WORD;
      K_TYPE:  rd_val = type_val;
      K_CTRL:  rd_val = {{(DATA_W-1){1'b0}}, ctrl_q};
      default: begin
        for (int i = 0; i < NUM_RW; i++)
          if (kind == rw_kind(i)) rd_val = rw_q[i];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o      <= '0;
      ready_o      <= 1'b0;
      bad_access_o <= 1'b0;
    end else begin
      rdata_o      <= rd_en ? rd_val : '0;
      ready_o      <= sel_i;
      bad_access_o <= sel_i & is_bad;
    end
  end
endmodule

// File: rtl/cache_ctrl_stub_chk.sv
module cache_ctrl_stub_chk
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ready_o,
  input logic              bad_access_o
);
  logic [OFF_W-1:0] off;
  assign off = addr_i[OFF_W-1:0];

  // R10
  ready_follows_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> ready_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (!ready_o && !bad_access_o && rdata_o == '0));

  // R2
  id_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && off == OFF_ID) |=> (rdata_o == ID_WORD && !bad_access_o));

  // R3
  ctrl_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && off == OFF_CTRL) |=> (rdata_o[DATA_W-1:1] == '0));

  // R6
  maint_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && off >= MAINT_LO && off < MAINT_HI) |=> (rdata_o == '0 && !bad_access_o));

  // R8
  bad_in_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_access_o |-> ready_o);
endmodule

bind cache_ctrl_stub cache_ctrl_stub_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .ready_o      (ready_o),
  .bad_access_o (bad_access_o)
);

// File: tb/sim_cache_ctrl_stub.sv
module sim_cache_ctrl_stub;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        ready, bad;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_type;
  logic        m_ctrl;
  logic [31:0] m_rw [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctrl_stub u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .bad_access_o(bad)
  );

  task automatic model_reset();
    m_type = 32'h1C10_0100;
    m_ctrl = 1'b0;
    m_rw.delete();
    m_rw[32'h104] = 32'h0202_0000;
    m_rw[32'h108] = 0;
    m_rw[32'h10C] = 0;
    m_rw[32'hC00] = 0;
    m_rw[32'hC04] = 0;
  endtask

  task automatic model(input bit w, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] ed, output bit eb);
    int o;
    logic [31:0] f;
    o = int'(a & 32'hFFF);
    ed = 0; eb = 0;
    if (o >= 'h730 && o < 'h800) begin
    end else if (o == 0) begin
      if (w) eb = 1; else ed = 32'h4100_00C8;
    end else if (o == 4) begin
      if (w) eb = 1;
      else begin
        f = {27'd0, m_rw[32'h104][19:17], 1'b0, m_rw[32'h104][16]};
        m_type = m_type | (f << 18) | (f << 6);
        ed = m_type;
      end
    end else if (o == 'h100) begin
      if (w) m_ctrl = d[0]; else ed = {31'd0, m_ctrl};
    end else if (m_rw.exists(o)) begin
      if (w) m_rw[o] = d; else ed = m_rw[o];
    end else if (o == 'hF40 || o == 'hF60 || o == 'hF80) begin
    end else begin
      eb = 1;
    end
  endtask

  task automatic step(input bit s, input bit w, input logic [31:0] a,
                      input logic [31:0] d, input string req);
    logic [31:0] ed;
    bit eb;
    ed = 0; eb = 0;
    sel = s; we = w; addr = a; wdata = d;
    if (s) model(w, a, d, ed, eb);
    @(negedge clk);
    vectors++;
    if (ready !== s || rdata !== ed || bad !== eb) begin
      miscompares++;
      $display("FAIL %s addr=%h we=%0b: got ready=%0b rdata=%h bad=%0b, expected ready=%0b rdata=%h bad=%0b",
               req, a, w, ready, rdata, bad, s, ed, eb);
    end
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [31:0] a, input string req);
    step(1, 0, a, 32'h0, req);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string req);
    step(1, 1, a, d, req);
  endtask

  task automatic idle(input string req);
    step(0, 0, 32'h0, 32'h0, req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      miscompares++;
      $display("FAIL watchdog: got cycle %0d, expected done by %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    vectors++;
    if (ready !== 0 || rdata !== 0 || bad !== 0) begin
      miscompares++;
      $display("FAIL R1 outputs in reset: got %0b %h %0b, expected 0 0 0", ready, rdata, bad);
    end
    rst_n = 1;
    idle("R10");

    // R1 reset values, R2 identity, R5 geometry at default
    rd(32'h000, "R2");
    rd(32'h004, "R5");
    foreach (m_rw[k]) rd(k, "R1");
    rd(32'h100, "R1");

    // R3 control keeps bit 0 only
    wr(32'h100, 32'hFFFF_FFFF, "R3");
    rd(32'h100, "R3");
    wr(32'h100, 32'hFFFF_FFFE, "R3");
    rd(32'h100, "R3");

    // R4 full-width registers, back to back
    wr(32'h108, 32'hDEAD_BEEF, "R4");
    wr(32'h10C, 32'h1234_5678, "R4");
    wr(32'hC00, 32'hA5A5_0000, "R4");
    wr(32'hC04, 32'hFFFF_FFFF, "R4");
    foreach (m_rw[k]) rd(k, "R4");

    // R5 accumulation through the auxiliary fields
    wr(32'h104, 32'h000F_0000, "R5");
    rd(32'h004, "R5");
    rd(32'h004, "R5");
    wr(32'h104, 32'h0000_0000, "R5");
    rd(32'h004, "R5");
    wr(32'h004, 32'h0, "R5");
    rd(32'h004, "R5");

    // R2 identity is read-only
    wr(32'h000, 32'hFFFF_FFFF, "R2");
    rd(32'h000, "R2");

    // R6 maintenance window
    wr(32'h730, 32'hFFFF_FFFF, "R6");
    wr(32'h7FC, 32'h1, "R6");
    rd(32'h730, "R6");
    rd(32'h7FF, "R6");
    rd(32'h72C, "R8");
    rd(32'h800, "R8");
    rd(32'h108, "R6");

    // R7 silent offsets
    wr(32'hF40, 32'h1, "R7");
    rd(32'hF60, "R7");
    rd(32'hF80, "R7");

    // R8 undecoded offsets
    wr(32'h200, 32'hFFFF_FFFF, "R8");
    idle("R8");
    rd(32'h010, "R8");
    foreach (m_rw[k]) rd(k, "R8");

    // R9 aliasing above bit 11
    wr(32'h0000_5104, 32'h0002_0000, "R9");
    rd(32'h0000_0104, "R9");
    wr(32'hABC0_0108, 32'h0000_0077, "R9");
    rd(32'h7770_1108, "R9");
    rd(32'hFFFF_F004, "R9");

    // R10 gaps between accesses
    idle("R10");
    idle("R10");
    rd(32'h100, "R10");
    idle("R10");

    // R1 asynchronous reset restores everything
    rst_n = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
    rd(32'h004, "R1");
    rd(32'h104, "R1");
    rd(32'h108, "R1");

    finish_run();
  end
endmodule